// File: doc/BRIEF.md
# Smooth Level Rebalancer

A cascaded rectifier built from several three-level modules needs its per-module output levels shuffled so that the DC-link capacitors of all modules stay at the same voltage, even when the modules carry unequal loads. This block sits behind the carrier-based modulator. On every control-period strobe it compares the total level the modulator asks for with the sum of the levels the modules are currently applying. It then moves selected modules one level step toward that total. The choice of module depends on how the DC-link voltages rank against each other and on the sign of the line current. No module ever moves more than one level in one update, so a module can never jump directly between the two extreme levels.

Balancing turns on by itself once bal_en is high and any module's DC-link voltage rises above a programmable threshold. It then stays on for as long as bal_en remains high. While balancing is off, each update simply copies the modulator's per-module levels to the outputs. The level reference is always the sum of the modulator's per-module levels, so rearranging the levels never changes the total voltage the converter synthesizes.

Top module: `smooth_level_rebalancer`

## Requirements
- R1: While rst_n is low, every output level is 0 and balancing is off.
- R2: Output levels change only in the clock cycle after a cycle in which tick is high. Changing any other input while tick is low leaves lvl_out unchanged.
- R3: While balancing is off, a tick loads each module's output level from its modulator level. Levels are 3-bit two's-complement values from -2 to +2, and module i occupies bits 3i+2 down to 3i of both mod_lvl and lvl_out.
- R4: Balancing turns on at the clock edge after bal_en is high while some module's vdc (unsigned, module i at bits VW*i+VW-1 down to VW*i) is strictly greater than thr. It stays on while bal_en remains high, even after every voltage has fallen below thr. It turns off at the clock edge after bal_en goes low.
- R5: Define the difference as the sum of mod_lvl levels minus the sum of lvl_out levels. While balancing is on and this difference is zero, a tick leaves every level unchanged, for either value of cur_pos.
- R6: With balancing on, a positive difference and cur_pos = 1 (positive current), a tick adds one to the lowest-voltage module among those below +2.
- R7: With balancing on, a positive difference and cur_pos = 0 (negative current), a tick adds one to the highest-voltage module among those below +2.
- R8: With balancing on, a negative difference and cur_pos = 1, a tick subtracts one from the highest-voltage module among those above -2.
- R9: With balancing on, a negative difference and cur_pos = 0, a tick subtracts one from the lowest-voltage module among those above -2.
- R10: When the magnitude of the difference is k > 1, one tick steps the first k eligible modules in the preference order of R6 to R9. If fewer than k modules are eligible, every eligible module is stepped once.
- R11: While balancing is on, each module's level changes by at most one per tick, and all levels stay within -2 to +2.
- R12: Modules with equal voltages are ranked by index, and the lower index is preferred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Control-period update strobe |
| bal_en | input | 1 | Allows automatic balancing |
| cur_pos | input | 1 | Line current sign, 1 = positive |
| thr | input | VW | DC-link voltage threshold that turns balancing on |
| mod_lvl | input | 3*N_MOD | Modulator levels per module, signed |
| vdc | input | VW*N_MOD | DC-link voltage per module, unsigned |
| lvl_out | output | 3*N_MOD | Applied level per module, signed |

## Verification
The range and single-step properties assume that every modulator level lies between -2 and +2. The 3-bit encoding also allows -4, -3 and +3, and those codes would break the properties while balancing is off. The bench builds every modulator vector from values in the legal range only. The sum-progress properties assume that the reference sum cannot exceed what N_MOD modules can reach; this follows from the legal range of the levels. The bench holds vdc, cur_pos and bal_en steady for two clocks before each strobe, so the turn-on state has settled when the update samples it.

// File: rtl/srl_pkg.sv
package srl_pkg;

  // Signed module level, legal range -2 .. +2
  typedef logic signed [2:0] lvl_t;

  localparam lvl_t LVL_HI = 3'sd2;
  localparam lvl_t LVL_LO = -3'sd2;

  localparam int LVL_W = 3;

endpackage

// File: rtl/srl_arm.sv
module srl_arm #(
  parameter int N_MOD = 4,
  parameter int VW    = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bal_en,
  input  logic [N_MOD*VW-1:0] vdc,
  input  logic [VW-1:0]       thr,
  output logic                armed
);

  logic [N_MOD-1:0] over;
  logic             armed_q;
  logic             armed_d;

  // One threshold comparator per module
  for (genvar gi = 0; gi < N_MOD; gi++) begin : g_cmp
    assign over[gi] = vdc[gi*VW +: VW] > thr;
  end

  always_comb begin
    armed_d = bal_en & (armed_q | (|over));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
    end
  end

  assign armed = armed_q;

  // R4: an over-threshold voltage with bal_en turns balancing on
  a_r4_arm_on: assert property (@(posedge clk) disable iff (!rst_n)
    (bal_en && (|over)) |=> armed_q)
    else $error("balancing did not turn on");

  // R4: dropping bal_en turns balancing off
  a_r4_arm_off: assert property (@(posedge clk) disable iff (!rst_n)
    !bal_en |=> !armed_q)
    else $error("balancing stayed on without bal_en");

  // R4: once on, stays on while bal_en holds
  a_r4_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && bal_en) |=> armed_q)
    else $error("balancing dropped while enabled");

endmodule

// File: rtl/srl_rank.sv
module srl_rank #(
  parameter int N_MOD = 4,
  parameter int VW    = 12,
  parameter int RW    = 6
) (
  input  logic [N_MOD*VW-1:0] vdc,
  input  logic [N_MOD-1:0]    elig,
  input  logic                low_first,
  output logic [N_MOD*RW-1:0] rank
);

  // Row gi counts the eligible modules preferred over module gi.
  for (genvar gi = 0; gi < N_MOD; gi++) begin : g_row
    logic [VW-1:0] v_self;
    logic [RW-1:0] cnt;

    assign v_self = vdc[gi*VW +: VW];

    always_comb begin
      cnt = '0;
      for (int j = 0; j < N_MOD; j++) begin
        logic [VW-1:0] v_other;
        logic          wins;
        v_other = vdc[j*VW +: VW];
        wins    = 1'b0;
        if ((j != gi) && elig[j]) begin
          if (v_other == v_self) begin
            wins = (j < gi);
          end else if (low_first) begin
            wins = (v_other < v_self);
          end else begin
            wins = (v_other > v_self);
          end
        end
        if (wins) begin
          cnt = cnt + RW'(1);
        end
      end
    end

    assign rank[gi*RW +: RW] = cnt;
  end

endmodule

// File: rtl/srl_sum.sv
module srl_sum #(
  parameter int N_MOD = 4,
  parameter int SW    = 6
) (
  input  logic [N_MOD*3-1:0]   lvls,
  output logic signed [SW-1:0] total
);

  always_comb begin
    total = '0;
    for (int i = 0; i < N_MOD; i++) begin
      total = total + $signed({{(SW-3){lvls[3*i+2]}}, lvls[3*i +: 3]});
    end
  end

endmodule

// File: rtl/srl_lane.sv
module srl_lane
  import srl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic armed,
  input  lvl_t pass_lvl,
  input  logic sel,
  input  logic up,
  output lvl_t lvl
);

  lvl_t lvl_q;
  lvl_t lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (!armed) begin
      lvl_d = pass_lvl;
    end else if (sel) begin
      lvl_d = up ? (lvl_q + 3'sd1) : (lvl_q - 3'sd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (tick) begin
      lvl_q <= lvl_d;
    end
  end

  assign lvl = lvl_q;

  // R2: no strobe, no change
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(lvl_q))
    else $error("level moved without a strobe");

  // R3: pass-through while balancing is off
  a_r3_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !armed) |=> (lvl_q == $past(pass_lvl)))
    else $error("pass-through level mismatch");

  // R11: at most one step per update while balancing
  a_r11_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && armed) |=> ((lvl_q == $past(lvl_q)) ||
                         (lvl_q == ($past(lvl_q) + 3'sd1)) ||
                         (lvl_q == ($past(lvl_q) - 3'sd1))))
    else $error("level jumped by more than one step");

  // R11: selection never pushes a saturated lane
  a_r11_no_push_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && armed && sel) |-> (up ? (lvl_q != LVL_HI) : (lvl_q != LVL_LO)))
    else $error("saturated lane selected");

  // R11: legal level range
  a_r11_range: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q >= LVL_LO) && (lvl_q <= LVL_HI))
    else $error("level out of range");

endmodule

// File: rtl/smooth_level_rebalancer.sv
module smooth_level_rebalancer
  import srl_pkg::*;
#(
  parameter int N_MOD = 4,
  parameter int VW    = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  bal_en,
  input  logic                  cur_pos,
  input  logic [VW-1:0]         thr,
  input  logic [N_MOD*3-1:0]    mod_lvl,
  input  logic [N_MOD*VW-1:0]   vdc,
  output logic [N_MOD*3-1:0]    lvl_out
);

  // Difference spans +/- 4*N_MOD; one extra bit for sign
  localparam int MW = $clog2(4*N_MOD + 1) + 1;
  localparam int RW = MW;

  logic                  armed;
  logic signed [MW-1:0]  ref_sum;
  logic signed [MW-1:0]  cur_sum;
  logic signed [MW-1:0]  diff;
  logic [MW-1:0]         mag;
  logic                  go_up;
  logic                  go_dn;
  logic                  low_first;
  logic [N_MOD-1:0]      elig;
  logic [N_MOD-1:0]      sel;
  logic [N_MOD-1:0]      leader;
  logic [N_MOD*RW-1:0]   rank;
  lvl_t                  lvl_w [N_MOD];

  srl_arm #(.N_MOD(N_MOD), .VW(VW)) u_arm (
    .clk    (clk),
    .rst_n  (rst_n),
    .bal_en (bal_en),
    .vdc    (vdc),
    .thr    (thr),
    .armed  (armed)
  );

  srl_sum #(.N_MOD(N_MOD), .SW(MW)) u_ref_sum (
    .lvls  (mod_lvl),
    .total (ref_sum)
  );

  srl_sum #(.N_MOD(N_MOD), .SW(MW)) u_cur_sum (
    .lvls  (lvl_out),
    .total (cur_sum)
  );

  always_comb begin
    diff      = ref_sum - cur_sum;
    go_up     = (diff > 0);
    go_dn     = diff[MW-1];
    mag       = go_dn ? MW'(-diff) : MW'(diff);
    // positive current with a rise, or negative current with a fall
    low_first = (go_up == cur_pos);
  end

  always_comb begin
    for (int i = 0; i < N_MOD; i++) begin
      elig[i] = (go_up && (lvl_w[i] < LVL_HI)) ||
                (go_dn && (lvl_w[i] > LVL_LO));
    end
  end

  srl_rank #(.N_MOD(N_MOD), .VW(VW), .RW(RW)) u_rank (
    .vdc       (vdc),
    .elig      (elig),
    .low_first (low_first),
    .rank      (rank)
  );

  always_comb begin
    for (int i = 0; i < N_MOD; i++) begin
      sel[i]    = elig[i] && (rank[i*RW +: RW] < mag);
      leader[i] = elig[i] && (rank[i*RW +: RW] == '0);
    end
  end

  for (genvar gi = 0; gi < N_MOD; gi++) begin : g_lane
    srl_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .armed    (armed),
      .pass_lvl (lvl_t'(mod_lvl[gi*3 +: 3])),
      .sel      (sel[gi]),
      .up       (go_up),
      .lvl      (lvl_w[gi])
    );
  end

  always_comb begin
    for (int i = 0; i < N_MOD; i++) begin
      lvl_out[i*3 +: 3] = lvl_w[i];
    end
  end

  // R5: balanced sum leaves every level in place
  a_r5_hold_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && armed && (diff == 0)) |=> $stable(lvl_out))
    else $error("levels moved with zero difference");

  // R6/R7: a rise request lifts the applied sum
  a_r6_sum_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && armed && go_up) |=> (cur_sum > $past(cur_sum)))
    else $error("sum did not rise");

  // R8/R9: a fall request lowers the applied sum
  a_r8_sum_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && armed && go_dn) |=> (cur_sum < $past(cur_sum)))
    else $error("sum did not fall");

  // R10: stepping never overshoots the reference
  a_r10_no_overshoot_up: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && armed && go_up) |=> (cur_sum <= $past(ref_sum)))
    else $error("rise overshot the reference");

  a_r10_no_overshoot_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && armed && go_dn) |=> (cur_sum >= $past(ref_sum)))
    else $error("fall overshot the reference");

  // R10: no more lanes stepped than the difference asks for
  a_r10_step_count: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && armed) |-> ($countones(sel) <= mag))
    else $error("too many lanes selected");

  // R12: with any eligible lane, exactly one heads the order
  a_r12_single_leader: assert property (@(posedge clk) disable iff (!rst_n)
    (|elig) |-> $onehot(leader))
    else $error("rank order has no unique leader");

endmodule

// File: tb/sim_smooth_level_rebalancer.sv
module sim_smooth_level_rebalancer;

  localparam int NM  = 4;
  localparam int VWB = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic              bal_en = 1'b0;
  logic              cur_pos = 1'b0;
  logic [VWB-1:0]    thr = VWB'(100);
  logic [NM*3-1:0]   mod_lvl = '0;
  logic [NM*VWB-1:0] vdc = '0;
  logic [NM*3-1:0]   lvl_out;

  always #4 clk = ~clk;   // 125 MHz

  smooth_level_rebalancer #(.N_MOD(NM), .VW(VWB)) u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .bal_en  (bal_en),
    .cur_pos (cur_pos),
    .thr     (thr),
    .mod_lvl (mod_lvl),
    .vdc     (vdc),
    .lvl_out (lvl_out)
  );

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  int  exp_l [NM];
  int  mod_a [NM];
  int  v_a   [NM];
  bit  arm_m = 1'b0;
  int  thr_i = 100;

  logic [NM*3-1:0] exp_q [$];
  string           tag_q [$];

  function automatic logic [NM*3-1:0] pack_exp();
    logic [NM*3-1:0] r;
    for (int i = 0; i < NM; i++) r[3*i +: 3] = 3'(exp_l[i]);
    return r;
  endfunction

  task automatic check_vec(input string tag, input logic [NM*3-1:0] got,
                           input logic [NM*3-1:0] want);
    n_run++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: lvl_out=%h expected %h", tag, got, want);
    end
  endtask

  // Apply inputs, then let the turn-on state settle
  task automatic set_in(input int m0, input int m1, input int m2, input int m3,
                        input int v0, input int v1, input int v2, input int v3,
                        input bit cp, input bit en);
    bit any_over;
    @(negedge clk);
    mod_a[0] = m0; mod_a[1] = m1; mod_a[2] = m2; mod_a[3] = m3;
    v_a[0] = v0; v_a[1] = v1; v_a[2] = v2; v_a[3] = v3;
    any_over = 1'b0;
    for (int i = 0; i < NM; i++) begin
      mod_lvl[3*i +: 3]   = 3'(mod_a[i]);
      vdc[VWB*i +: VWB]   = VWB'(v_a[i]);
      if (v_a[i] > thr_i) any_over = 1'b1;
    end
    cur_pos = cp;
    bal_en  = en;
    arm_m   = en && (arm_m || any_over);
    repeat (2) @(negedge clk);
  endtask

  // Driver: predict the update, queue it, pulse the strobe
  task automatic do_tick(input string tag);
    int ref_s;
    int cur_s;
    int dm;
    int k;
    bit up;
    bit lowf;
    bit picked [NM];
    ref_s = 0;
    cur_s = 0;
    for (int i = 0; i < NM; i++) begin
      ref_s += mod_a[i];
      cur_s += exp_l[i];
      picked[i] = 1'b0;
    end
    if (!arm_m) begin
      for (int i = 0; i < NM; i++) exp_l[i] = mod_a[i];
    end else begin
      dm   = ref_s - cur_s;
      up   = (dm > 0);
      k    = (dm < 0) ? -dm : dm;
      lowf = (up == cur_pos);
      for (int n = 0; n < k; n++) begin
        int best;
        best = -1;
        for (int i = 0; i < NM; i++) begin
          bit ok;
          ok = up ? (exp_l[i] < 2) : (exp_l[i] > -2);
          if (ok && !picked[i]) begin
            if (best < 0) best = i;
            else if (lowf && (v_a[i] < v_a[best])) best = i;
            else if (!lowf && (v_a[i] > v_a[best])) best = i;
          end
        end
        if (best >= 0) picked[best] = 1'b1;
      end
      for (int i = 0; i < NM; i++) begin
        if (picked[i]) exp_l[i] = up ? exp_l[i] + 1 : exp_l[i] - 1;
      end
    end
    exp_q.push_back(pack_exp());
    tag_q.push_back(tag);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: compare each strobed update against the queue
  always @(posedge clk) begin
    if (rst_n && tick) begin
      #2;
      if (exp_q.size() == 0) begin
        n_run++;
        n_fail++;
        $display("FAIL R2 monitor: lvl_out=%h expected no update", lvl_out);
      end else begin
        check_vec(tag_q.pop_front(), lvl_out, exp_q.pop_front());
      end
    end
  end

  initial begin
    for (int i = 0; i < NM; i++) begin
      exp_l[i] = 0; mod_a[i] = 0; v_a[i] = 0;
    end
    repeat (3) @(negedge clk);
    check_vec("R1 levels during reset", lvl_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check_vec("R1 levels after reset", lvl_out, '0);

    // Pass-through while off
    set_in(1, -2, 2, 0, 50, 50, 50, 50, 1'b1, 1'b0);
    do_tick("R3 pass-through pattern A");
    set_in(0, 0, 0, 0, 50, 50, 50, 50, 1'b0, 1'b0);
    check_vec("R2 hold without strobe", lvl_out, pack_exp());
    set_in(-1, 2, 0, -2, 50, 50, 50, 50, 1'b0, 1'b0);
    do_tick("R3 pass-through pattern B");

    // At threshold (not above): still off
    set_in(0, 0, 0, 0, 100, 100, 100, 100, 1'b1, 1'b1);
    do_tick("R4 equal to threshold stays off");

    // Turn on; each current/difference quadrant
    set_in(1, 0, 0, 0, 300, 200, 150, 250, 1'b1, 1'b1);
    do_tick("R6 rise, positive current, lowest voltage");
    set_in(1, 1, 0, 0, 300, 200, 150, 250, 1'b0, 1'b1);
    do_tick("R7 rise, negative current, highest voltage");
    set_in(1, 0, 0, 0, 300, 200, 150, 250, 1'b1, 1'b1);
    do_tick("R8 fall, positive current, highest voltage");
    set_in(0, 0, 0, 0, 300, 200, 150, 250, 1'b0, 1'b1);
    do_tick("R9 fall, negative current, lowest voltage");
    set_in(0, 0, 0, 0, 300, 200, 150, 250, 1'b1, 1'b1);
    do_tick("R5 zero difference, positive current");
    set_in(0, 0, 0, 0, 300, 200, 150, 250, 1'b0, 1'b1);
    do_tick("R5 zero difference, negative current");

    // Sticky after voltages drop, multi-step in rank order
    set_in(2, 1, 0, 0, 50, 60, 70, 80, 1'b1, 1'b1);
    do_tick("R4 R10 sticky turn-on, three lowest stepped");
    set_in(2, 2, 2, 2, 50, 60, 70, 80, 1'b1, 1'b1);
    do_tick("R10 difference exceeds eligible count");
    do_tick("R6 saturated modules excluded");

    // Full-scale reversal must walk one step at a time
    set_in(-2, -2, -2, -2, 50, 60, 70, 80, 1'b1, 1'b1);
    do_tick("R11 reversal first step");
    do_tick("R11 reversal second step");

    // Equal voltages
    set_in(1, 0, 0, 0, 200, 200, 200, 200, 1'b1, 1'b1);
    do_tick("R12 tie, lowest-first order");
    set_in(1, 1, 0, 0, 200, 200, 200, 200, 1'b0, 1'b1);
    do_tick("R12 tie, highest-first order");
    set_in(1, 1, 1, 0, 200, 200, 200, 200, 1'b0, 1'b1);
    do_tick("R12 tie, saturated index skipped");

    // Turn off again
    set_in(-2, 2, -1, 1, 300, 300, 300, 300, 1'b1, 1'b0);
    do_tick("R4 R3 pass-through after bal_en drops");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule